// File: doc/BRIEF.md
# Dual-Speed Clock Enable Controller

This block produces the clock-enable strobes of an 8051-style microcontroller from one oscillator clock. Every output is a synchronous enable in the oscillator domain, so no clock is gated or derived. A mode bit selects how fast the enables run. In standard speed they fire on every second oscillator cycle. In double speed they fire on every oscillator cycle. The CPU-core enable and the peripheral enable always follow the mode together.

Two power-reduction requests can hold the enables low. Idle stops only the CPU-core enable, and the peripherals keep running. Power-down stops both enables and wins over idle. The block also counts CPU enables and raises a machine-cycle strobe on every sixth one. The machine cycle is therefore 12 oscillator cycles long in standard speed and 6 in double speed. The mode bit and both power requests take effect only at the end of a divider pair. As a result, no enable pulse is ever cut short or doubled by a change.

Top module: `clk_enable_ctrl`

## Requirements
- R1: After reset is released the block runs at standard speed. All three outputs are low in the first oscillator cycle, and the first CPU and peripheral enables appear in the second cycle.
- R2: At standard speed, both cpuEn and perEn are high on every second oscillator cycle, namely the cycles where the 1-bit divider phase equals 1, and are low in between.
- R3: At double speed, both cpuEn and perEn are high on every oscillator cycle.
- R4: fastMode (1 = double speed, 0 = standard) is taken in only at a clock edge where the divider phase equals 1. A change presented at any other edge waits for the next such edge, and cpuEn and perEn always switch speed together.
- R5: While idle is in force (idleReq = 1, taken in at a phase-1 edge), cpuEn stays low and perEn keeps its normal pattern.
- R6: While power-down is in force (pdReq = 1, taken in at a phase-1 edge), cpuEn and perEn both stay low, whatever idleReq is.
- R7: machEn is high together with every sixth cpuEn pulse, counted from reset. Its period is therefore 12 oscillator cycles at standard speed and 6 at double speed, and the count holds while cpuEn is stopped.
- R8: When idle and power-down are cleared, the enables resume at the next phase-1 edge. The divider phase keeps running through any gating, and the machine count continues from its held value.
- R9: An asserted rstN (active low, asynchronous) forces all outputs low at once and clears the mode, both gates, the divider phase and the machine count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fastMode | input | 1 | Speed select: 1 = every cycle, 0 = every second cycle |
| idleReq | input | 1 | Idle request: stops the CPU-core enable |
| pdReq | input | 1 | Power-down request: stops both enables |
| cpuEn | output | 1 | CPU-core clock enable |
| perEn | output | 1 | Peripheral clock enable |
| machEn | output | 1 | Machine-cycle strobe |

## Verification
A divider phase that is off by one shows up at the ports at once: at standard speed, cpuEn and perEn land in the wrong cycle within two oscillator cycles. A mode or gate register that loads at the wrong edge moves the first affected enable by one cycle at the switch point. A machine counter that miscounts, or that keeps counting while gated, shifts machEn by a whole enable period. That shift is visible no later than the next machine cycle, so the bench compares every output in every cycle against its own model.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;

  // Strobes passed from the control to the datapath every oscillator cycle
  typedef struct packed {
    logic cpuGo;   // CPU-core enable for this cycle
    logic perGo;   // peripheral enable for this cycle
  } strobe_t;

endpackage

// File: rtl/clk_en_ctrl.sv
module clk_en_ctrl
  import clk_en_pkg::*;
#(
  parameter int PRESCALE = 2   // standard-speed divide ratio, at least 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    fastMode,
  input  logic    idleReq,
  input  logic    pdReq,
  output strobe_t strobe
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PHASE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;
  logic          phaseLast;
  logic          fastAct;
  logic          idleGate;
  logic          pdGate;
  logic          tick;

  assign phaseLast = (phase == PHASE_LAST);

  // Free-running divider phase; it keeps counting while gated (R8)
  generate
    if (PRESCALE > 1) begin : gPhase
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          phase <= '0;
        else if (phaseLast) phase <= '0;
        else                phase <= phase + 1'b1;
      end
    end else begin : gNoPhase
      assign phase = PHASE_LAST;
    end
  endgenerate

  // Mode and power gates load only at the end of a divider group (R4, R5, R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastAct  <= 1'b0;
      idleGate <= 1'b0;
      pdGate   <= 1'b0;
    end else if (phaseLast) begin
      fastAct  <= fastMode;
      idleGate <= idleReq;
      pdGate   <= pdReq;
    end
  end

  assign tick         = fastAct | phaseLast;
  assign strobe.perGo = tick & ~pdGate;
  assign strobe.cpuGo = tick & ~pdGate & ~idleGate;

  // R4: the active mode only moves at a group boundary
  a_r4_mode_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (fastAct != $past(fastAct)) |-> $past(phaseLast));

  // R2: at standard speed a peripheral enable is never followed by another unless the mode just went fast
  a_r2_std_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (!fastAct && strobe.perGo) |=> (!strobe.perGo || fastAct));

  // R6: a power-down request taken in at a boundary stops the peripheral enable
  a_r6_pd_stops_per: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pdReq) && $past(phaseLast)) |-> !strobe.perGo);

  // R5: an idle request taken in at a boundary stops the CPU enable
  a_r5_idle_stops_cpu: assert property (@(posedge clk) disable iff (!rstN)
    ($past(idleReq) && $past(phaseLast)) |-> !strobe.cpuGo);

endmodule

// File: rtl/clk_en_dp.sv
module clk_en_dp
  import clk_en_pkg::*;
#(
  parameter int MACH_TICKS = 6   // CPU enables per machine cycle
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  output logic    cpuEn,
  output logic    perEn,
  output logic    machEn
);

  localparam int CW = (MACH_TICKS > 1) ? $clog2(MACH_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MACH_TICKS - 1);

  logic [CW-1:0] machCnt;
  logic          cntWrap;

  assign cntWrap = (machCnt == CNT_LAST);

  // Machine counter advances on CPU enables only, and holds while gated (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             machCnt <= '0;
    else if (strobe.cpuGo) machCnt <= cntWrap ? '0 : machCnt + 1'b1;
  end

  assign cpuEn  = strobe.cpuGo;
  assign perEn  = strobe.perGo;
  assign machEn = strobe.cpuGo & cntWrap;

  // R7: the machine strobe never lasts two cycles in a row
  a_r7_mach_single: assert property (@(posedge clk) disable iff (!rstN)
    machEn |=> !machEn);

  // R7: the count holds while the CPU enable is stopped
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cpuEn |=> $stable(machCnt));

  // R7: the count stays inside its range
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    machCnt <= CNT_LAST);

  // R5: the CPU never runs without the peripherals
  a_r5_cpu_needs_per: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> perEn);

endmodule

// File: rtl/clk_enable_ctrl.sv
module clk_enable_ctrl
  import clk_en_pkg::*;
#(
  parameter int PRESCALE   = 2,
  parameter int MACH_TICKS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic fastMode,
  input  logic idleReq,
  input  logic pdReq,
  output logic cpuEn,
  output logic perEn,
  output logic machEn
);

  strobe_t strobe;

  clk_en_ctrl #(.PRESCALE(PRESCALE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .fastMode (fastMode),
    .idleReq  (idleReq),
    .pdReq    (pdReq),
    .strobe   (strobe)
  );

  clk_en_dp #(.MACH_TICKS(MACH_TICKS)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cpuEn  (cpuEn),
    .perEn  (perEn),
    .machEn (machEn)
  );

endmodule

// File: tb/clk_enable_ctrl_test.sv
`timescale 1ns/1ps
module clk_enable_ctrl_test;

  localparam int PRESCALE   = 2;
  localparam int MACH_TICKS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastMode = 1'b0;
  logic idleReq = 1'b0;
  logic pdReq = 1'b0;
  logic cpuEn, perEn, machEn;

  int checks = 0;
  int errors = 0;

  // bench model state
  int   mPhase = 0;
  int   mCnt = 0;
  logic mFast = 1'b0;
  logic mIdle = 1'b0;
  logic mPd = 1'b0;

  always #2.5 clk = ~clk;

  clk_enable_ctrl #(.PRESCALE(PRESCALE), .MACH_TICKS(MACH_TICKS)) uut (
    .clk(clk), .rstN(rstN), .fastMode(fastMode), .idleReq(idleReq),
    .pdReq(pdReq), .cpuEn(cpuEn), .perEn(perEn), .machEn(machEn)
  );

  function automatic logic modelTick();
    return mFast || (mPhase == PRESCALE - 1);
  endfunction
  function automatic logic modelPer();
    return modelTick() && !mPd;
  endfunction
  function automatic logic modelCpu();
    return modelTick() && !mPd && !mIdle;
  endfunction
  function automatic logic modelMach();
    return modelCpu() && (mCnt == MACH_TICKS - 1);
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %0b expected %0b", tag, what, $time, got, exp);
    end
  endtask

  task automatic modelReset();
    mPhase = 0; mCnt = 0; mFast = 1'b0; mIdle = 1'b0; mPd = 1'b0;
  endtask

  // Drive inputs just after a falling edge, advance the model across the next
  // rising edge, then compare at the following falling edge.
  task automatic step(input logic f, input logic i, input logic p, input string tag = "");
    string tEn;
    string tM;
    fastMode = f; idleReq = i; pdReq = p;
    if (modelCpu()) mCnt = (mCnt == MACH_TICKS - 1) ? 0 : mCnt + 1;
    if (mPhase == PRESCALE - 1) begin
      mFast = f; mIdle = i; mPd = p; mPhase = 0;
    end else begin
      mPhase++;
    end
    @(negedge clk);
    if (tag != "") begin
      tEn = tag; tM = tag;
    end else begin
      tEn = mPd ? "R6" : mIdle ? "R5" : mFast ? "R3" : "R2";
      tM = "R7";
    end
    check(tEn, "cpuEn", cpuEn, modelCpu());
    check(tEn, "perEn", perEn, modelPer());
    check(tM, "machEn", machEn, modelMach());
  endtask

  // R9: asynchronous reset in mid-run
  task automatic doReset(input int n);
    rstN = 1'b0;
    #1;
    modelReset();
    check("R9", "cpuEn", cpuEn, 1'b0);
    check("R9", "perEn", perEn, 1'b0);
    check("R9", "machEn", machEn, 1'b0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R9", "cpuEn", cpuEn, 1'b0);
      check("R9", "machEn", machEn, 1'b0);
    end
    rstN = 1'b1;
    #0.5;
    check("R1", "cpuEn", cpuEn, 1'b0);
    check("R1", "perEn", perEn, 1'b0);
    check("R1", "machEn", machEn, 1'b0);
  endtask

  // R7: spacing between two machine strobes in a steady mode
  task automatic measure(input logic f, input int expPeriod);
    int last = -1;
    int gap = -1;
    for (int k = 0; k < 60 && gap < 0; k++) begin
      step(f, 1'b0, 1'b0);
      if (machEn === 1'b1) begin
        if (last >= 0) gap = k - last;
        last = k;
      end
    end
    check("R7", "machine period", gap == expPeriod, 1'b1);
    if (gap != expPeriod) $display("  R7 period got %0d expected %0d", gap, expPeriod);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset(3);

    // R1: first cycles after release
    for (int k = 0; k < 14; k++) step(1'b0, 1'b0, 1'b0, "R1");

    // R2 and R3 steady patterns plus machine periods (R7)
    measure(1'b0, 12);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, "R4");
    measure(1'b1, 6);

    // R4: change mode at a non-boundary edge, then at a boundary
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, "R4");
    while (mPhase != 0) step(1'b0, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, "R4");
    while (mPhase != PRESCALE - 1) step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, "R4");

    // R5: idle stops the CPU only
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, "R5");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0, "R5");

    // R6: power-down, alone and with idle
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b1, "R6");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b1, "R6");

    // R8: resume after clearing both gates
    for (int k = 0; k < 14; k++) step(1'b0, 1'b0, 1'b0, "R8");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1, "R8");
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 1'b0, "R8");

    // R9: reset in the middle of a run
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0);
    doReset(2);
    for (int k = 0; k < 14; k++) step(1'b0, 1'b0, 1'b0, "R1");

    // random traffic
    begin
      logic f = 1'b0;
      logic i = 1'b0;
      logic p = 1'b0;
      for (int k = 0; k < 1500; k++) begin
        if ($urandom % 30 == 0) f = ~f;
        if ($urandom % 8 == 0)  i = ($urandom % 3 == 0);
        if ($urandom % 12 == 0) p = ($urandom % 4 == 0);
        step(f, i, p);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule